// File: doc/BRIEF.md
# Trap-Level Stacked Control Register File

This block holds the control and status registers of a processor core. It has one combinational read port and one write port. Each port is addressed by a 5-bit register index, and the data width is 64 bits. Most registers are plain scalars. Five registers are stacks with one entry per trap level: the saved PC, the saved next-PC, the saved state, the trap type and the hypervisor saved state. An access to one of these reaches the entry at position (current trap level − 1).

A read-only version register is assembled from the configuration parameters. Two registered outputs give the implicit instruction and data address-space identifiers. They are recomputed from the trap level and the little-endian bit of the processor-state register whenever either register is written. Accesses that cannot be honoured raise a combinational error flag and change nothing.

Top module: `ctlrf_top`

## Requirements
- R1: After reset every register reads zero, except the hypervisor-state register (index 23), which reads 0x800. Both address-space outputs read 0x80 (primary).
- R2: Register map: 0 mulhi, 1 cond, 2 dasi, 3 tick, 4 softint, 5 tickcmp, 6 systick, 7 syscmp, 8 tpc, 9 tnpc, 10 tstate, 11 ttype, 12 tbase, 13 pstate, 14 tlevel, 15 pil, 16 curwin, 17 cansave, 18 canrest, 19 cleanwin, 20 otherwin, 21 winstate, 22 glevel, 23 hpstate, 24 htstate, 25 htbase, 26 version, 27 strand, 28 htickcmp. A write is stored at the clock edge. A read returns the stored value in the same cycle, so a read in the same cycle as a write returns the old value. The read data is zero when the read port is idle or the read is illegal.
- R3: A write to tbase (12) stores the data with bits [14:0] cleared.
- R4: Indices 8, 9, 10, 11 and 24 access the entry at position (tlevel − 1). Each trap level keeps its own value.
- R5: The version register (26) reads WIN_CNT | MAX_TL<<8 | MAX_GL<<16. A write to it is illegal and has no effect.
- R6: With tlevel = 0, both address-space outputs are 0x80. They are 0x88 when pstate bit 9 is set.
- R7: With 1 ≤ tlevel ≤ MAX_PTL, the instruction output is 0x04. The data output is 0x04, or 0x0C when pstate bit 9 is set.
- R8: With tlevel > MAX_PTL, both outputs are 0x14 (real).
- R9: The address-space outputs take the value implied by a tlevel or pstate write on the clock edge that stores the write.
- R10: The error flag is raised in the same cycle as an access to an index above 28, or to a stacked index while tlevel is 0 or above MAX_TL. While the flag is high, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Read register index |
| rd_data | output | 64 | Read data, combinational |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |
| acc_err | output | 1 | Illegal access in this cycle |
| inst_asi | output | 8 | Implicit instruction address space |
| data_asi | output | 8 | Implicit data address space |

## Verification
Read data and the error flag are combinational, so they are due in the cycle the request is presented. The bench samples them shortly after driving inputs on the falling edge. Writes and the address-space outputs settle at the next rising edge. The behavioural model commits each write at that edge, and the comparison of the selectors therefore happens in the following cycle against the updated model. This makes a tlevel write followed by any access a direct check of the one-edge latency.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
  localparam int XLEN  = 64;
  localparam int IDX_W = 5;
  localparam int NSTK  = 5;

  typedef enum logic [IDX_W-1:0] {
    CR_MULHI = 5'd0,  CR_COND = 5'd1,  CR_DASI = 5'd2,  CR_TICK = 5'd3,
    CR_SOFTINT = 5'd4, CR_TICKCMP = 5'd5, CR_SYSTICK = 5'd6, CR_SYSCMP = 5'd7,
    CR_TPC = 5'd8, CR_TNPC = 5'd9, CR_TSTATE = 5'd10, CR_TTYPE = 5'd11,
    CR_TBASE = 5'd12, CR_PSTATE = 5'd13, CR_TLEVEL = 5'd14, CR_PIL = 5'd15,
    CR_CURWIN = 5'd16, CR_CANSAVE = 5'd17, CR_CANREST = 5'd18, CR_CLEANWIN = 5'd19,
    CR_OTHERWIN = 5'd20, CR_WINSTATE = 5'd21, CR_GLEVEL = 5'd22, CR_HPSTATE = 5'd23,
    CR_HTSTATE = 5'd24, CR_HTBASE = 5'd25, CR_VERSION = 5'd26, CR_STRAND = 5'd27,
    CR_HTICKCMP = 5'd28
  } creg_e;

  localparam logic [7:0] AS_PRIMARY    = 8'h80;
  localparam logic [7:0] AS_PRIMARY_LE = 8'h88;
  localparam logic [7:0] AS_NUCLEUS    = 8'h04;
  localparam logic [7:0] AS_NUCLEUS_LE = 8'h0C;
  localparam logic [7:0] AS_REAL       = 8'h14;

  localparam int PSTATE_LE_BIT = 9;
  localparam int HPSTATE_RST_BIT = 11;
  localparam logic [XLEN-1:0] TBASE_MASK = ~64'h7FFF;

  function automatic logic is_impl(input logic [IDX_W-1:0] i);
    return i <= CR_HTICKCMP;
  endfunction

  function automatic logic is_stk(input logic [IDX_W-1:0] i);
    return (i == CR_TPC) || (i == CR_TNPC) || (i == CR_TSTATE) ||
           (i == CR_TTYPE) || (i == CR_HTSTATE);
  endfunction

  function automatic logic [2:0] stk_sel(input logic [IDX_W-1:0] i);
    case (i)
      CR_TPC:    return 3'd0;
      CR_TNPC:   return 3'd1;
      CR_TSTATE: return 3'd2;
      CR_TTYPE:  return 3'd3;
      default:   return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ctlrf_trap_stack.sv
module ctlrf_trap_stack #(
  parameter int NSTK  = 5,
  parameter int DEPTH = 6,
  parameter int W     = 64,
  parameter int SEL_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SEL_W-1:0]         wsel,
  input  logic [SLOT_W-1:0]        wslot,
  input  logic [W-1:0]             wdata,
  input  logic [SEL_W-1:0]         rsel,
  input  logic [SLOT_W-1:0]        rslot,
  output logic [W-1:0]             rdata
);
  localparam int N    = NSTK * DEPTH;
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [N];
  logic [W-1:0] mem_d [N];
  logic [IW-1:0] widx, ridx;

  assign widx  = IW'(int'(wsel) * DEPTH + int'(wslot));
  assign ridx  = IW'(int'(rsel) * DEPTH + int'(rslot));
  assign rdata = mem_q[ridx];

  always_comb begin
    mem_d = mem_q;
    if (we) mem_d[widx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  AST_STK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(wslot) < DEPTH && int'(wsel) < NSTK)); // R4
endmodule

// File: rtl/ctlrf_asi_sel.sv
module ctlrf_asi_sel
  import ctlrf_pkg::*;
#(
  parameter int MAX_PTL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [XLEN-1:0] tl_nx,
  input  logic            le_nx,
  output logic [7:0]      inst_q,
  output logic [7:0]      data_q
);
  logic [7:0] inst_d, data_d;

  always_comb begin
    if (tl_nx == '0) begin
      inst_d = le_nx ? AS_PRIMARY_LE : AS_PRIMARY;
      data_d = inst_d;
    end else if (tl_nx <= XLEN'(MAX_PTL)) begin
      inst_d = AS_NUCLEUS;
      data_d = le_nx ? AS_NUCLEUS_LE : AS_NUCLEUS;
    end else begin
      inst_d = AS_REAL;
      data_d = AS_REAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inst_q <= AS_PRIMARY;
      data_q <= AS_PRIMARY;
    end else if (upd) begin
      inst_q <= inst_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/ctlrf_top.sv
module ctlrf_top
  import ctlrf_pkg::*;
#(
  parameter int WIN_CNT = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [4:0]       rd_idx,
  output logic [63:0]      rd_data,
  input  logic             wr_en,
  input  logic [4:0]       wr_idx,
  input  logic [63:0]      wr_data,
  output logic             acc_err,
  output logic [7:0]       inst_asi,
  output logic [7:0]       data_asi
);
  localparam int NREG   = 1 << IDX_W;
  localparam int SLOT_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
  localparam int SEL_W  = 3;
  localparam logic [XLEN-1:0] VER_VAL =
    XLEN'(WIN_CNT) | (XLEN'(MAX_TL) << 8) | (XLEN'(MAX_GL) << 16);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [XLEN-1:0] scal_q [NREG];
  logic [XLEN-1:0] scal_d [NREG];
  logic [XLEN-1:0] tl_q, ps_q, stk_rdata;
  logic stk_ok, rd_bad, wr_bad, wr_go, stk_we, scal_we, asi_upd;
  logic [SLOT_W-1:0] slot;

  assign tl_q   = scal_q[CR_TLEVEL];
  assign ps_q   = scal_q[CR_PSTATE];
  assign stk_ok = (tl_q != '0) && (tl_q <= XLEN'(MAX_TL));
  assign slot   = SLOT_W'(tl_q - 1);

  assign rd_bad  = rd_en && (!is_impl(rd_idx) || (is_stk(rd_idx) && !stk_ok));
  assign wr_bad  = wr_en && (!is_impl(wr_idx) || (wr_idx == CR_VERSION) ||
                             (is_stk(wr_idx) && !stk_ok));
  assign acc_err = rd_bad || wr_bad;
  assign wr_go   = wr_en && !acc_err;
  assign stk_we  = wr_go && is_stk(wr_idx);
  assign scal_we = wr_go && !is_stk(wr_idx);
  assign asi_upd = scal_we && ((wr_idx == CR_TLEVEL) || (wr_idx == CR_PSTATE));

  always_comb begin
    scal_d = scal_q;
    if (scal_we)
      scal_d[wr_idx] = (wr_idx == CR_TBASE) ? (wr_data & TBASE_MASK) : wr_data;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      for (int i = 0; i < NREG; i++)
        scal_q[i] <= (i == int'(CR_HPSTATE)) ? (XLEN'(1) << HPSTATE_RST_BIT) : '0;
    end else if (scal_we) begin
      scal_q <= scal_d;
    end
  end

  ctlrf_trap_stack #(.NSTK(NSTK), .DEPTH(MAX_TL), .W(XLEN), .SEL_W(SEL_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (stk_we),
    .wsel  (stk_sel(wr_idx)),
    .wslot (slot),
    .wdata (wr_data),
    .rsel  (stk_sel(rd_idx)),
    .rslot (slot),
    .rdata (stk_rdata)
  );

  ctlrf_asi_sel #(.MAX_PTL(MAX_PTL)) u_asi (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .upd    (asi_upd),
    .tl_nx  (scal_d[CR_TLEVEL]),
    .le_nx  (scal_d[CR_PSTATE][PSTATE_LE_BIT]),
    .inst_q (inst_asi),
    .data_q (data_asi)
  );

  always_comb begin
    if (!rd_en || rd_bad)            rd_data = '0;
    else if (rd_idx == CR_VERSION)   rd_data = VER_VAL;
    else if (is_stk(rd_idx))         rd_data = stk_rdata;
    else                             rd_data = scal_q[rd_idx];
  end

  AST_TBASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_i_n)
    scal_q[CR_TBASE][14:0] == '0); // R3
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    acc_err |=> ($stable(tl_q) && $stable(ps_q) && $stable(inst_asi))); // R10
  AST_ASI_TL0: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tl_q == '0) |-> (inst_asi == data_asi &&
      inst_asi == (ps_q[PSTATE_LE_BIT] ? AS_PRIMARY_LE : AS_PRIMARY))); // R6
  AST_ASI_PRIV: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tl_q != '0 && tl_q <= XLEN'(MAX_PTL)) |-> (inst_asi == AS_NUCLEUS)); // R7
  AST_ASI_REAL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tl_q > XLEN'(MAX_PTL)) |-> (inst_asi == AS_REAL && data_asi == AS_REAL)); // R8
endmodule

// File: tb/tb_ctlrf_top.sv
module tb_ctlrf_top;
  localparam int WIN_CNT = 8, MAX_TL = 6, MAX_PTL = 2, MAX_GL = 3;
  localparam int I_TBASE = 12, I_PSTATE = 13, I_TLEVEL = 14, I_HPSTATE = 23, I_VERSION = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0] rd_idx = '0, wr_idx = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic acc_err;
  logic [7:0] inst_asi, data_asi;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_scal [32];
  logic [63:0] m_stk [5][MAX_TL];

  always #10 clk = ~clk;

  ctlrf_top #(.WIN_CNT(WIN_CNT), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .MAX_GL(MAX_GL)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .acc_err(acc_err),
    .inst_asi(inst_asi), .data_asi(data_asi));

  function automatic int slot_of(int i);
    case (i)
      8: return 0; 9: return 1; 10: return 2; 11: return 3; 24: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic bit illegal(int i, bit is_wr);
    logic [63:0] tl = m_scal[I_TLEVEL];
    if (i > 28) return 1;
    if (is_wr && i == I_VERSION) return 1;
    if (slot_of(i) >= 0 && (tl == 0 || tl > MAX_TL)) return 1;
    return 0;
  endfunction

  task automatic chk(logic [63:0] act, logic [63:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(bit re, int ri, bit we, int wi, logic [63:0] wd, string tag);
    logic [63:0] e_rd, tl;
    logic [7:0] e_i, e_d;
    bit e_err, le;
    @(negedge clk);
    rd_en = re; rd_idx = 5'(ri); wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    #2;
    tl = m_scal[I_TLEVEL];
    le = m_scal[I_PSTATE][9];
    e_err = (re && illegal(ri, 0)) || (we && illegal(wi, 1));
    if (!re || illegal(ri, 0)) e_rd = 0;
    else if (ri == I_VERSION) e_rd = 64'(WIN_CNT) | (64'(MAX_TL) << 8) | (64'(MAX_GL) << 16);
    else if (slot_of(ri) >= 0) e_rd = m_stk[slot_of(ri)][int'(tl) - 1];
    else e_rd = m_scal[ri];
    if (tl == 0) begin e_i = le ? 8'h88 : 8'h80; e_d = e_i; end
    else if (tl <= MAX_PTL) begin e_i = 8'h04; e_d = le ? 8'h0C : 8'h04; end
    else begin e_i = 8'h14; e_d = 8'h14; end
    chk(rd_data, e_rd, {tag, " rd_data"});
    chk(64'(acc_err), 64'(e_err), {tag, " acc_err"});
    chk(64'(inst_asi), 64'(e_i), {tag, " inst_asi"});
    chk(64'(data_asi), 64'(e_d), {tag, " data_asi"});
    @(posedge clk);
    if (we && !e_err) begin
      if (slot_of(wi) >= 0) m_stk[slot_of(wi)][int'(tl) - 1] = wd;
      else if (wi == I_TBASE) m_scal[wi] = wd & ~64'h7FFF;
      else m_scal[wi] = wd;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_scal[i] = 0;
    m_scal[I_HPSTATE] = 64'h800;
    for (int s = 0; s < 5; s++) for (int t = 0; t < MAX_TL; t++) m_stk[s][t] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 reset state (stacked reads at tlevel 0 also flag per R10)
    for (int i = 0; i < 29; i++) op(1, i, 0, 0, 0, "R1");
    op(1, I_VERSION, 0, 0, 0, "R5");
    // R2 scalar write/read, same-cycle read sees old value
    op(0, 0, 1, 0, 64'hDEAD_BEEF_0123_4567, "R2");
    op(1, 0, 1, 0, 64'h1111, "R2");
    op(1, 0, 0, 0, 0, "R2");
    op(0, 0, 1, 28, 64'hA5A5, "R2");
    op(1, 28, 0, 0, 0, "R2");
    // R3 tbase alignment
    op(0, 0, 1, I_TBASE, '1, "R3");
    op(1, I_TBASE, 0, 0, 0, "R3");
    // R10 stacked at tl 0
    op(0, 0, 1, 8, 64'h55, "R10");
    op(1, 8, 0, 0, 0, "R10");
    // R9/R7 tlevel write then stack R4
    op(0, 0, 1, I_TLEVEL, 1, "R9");
    op(0, 0, 1, 8, 64'hAAAA_0001, "R4");
    op(0, 0, 1, 24, 64'hBBBB_0001, "R4");
    op(0, 0, 1, I_TLEVEL, 2, "R7");
    op(0, 0, 1, 8, 64'hAAAA_0002, "R4");
    op(1, 8, 0, 0, 0, "R4");
    op(1, 24, 1, I_TLEVEL, 1, "R4");
    op(1, 8, 0, 0, 0, "R4");
    op(1, 24, 0, 0, 0, "R4");
    // R6/R7/R8 selector cases
    op(0, 0, 1, I_PSTATE, 64'h200, "R7");
    op(0, 0, 1, I_TLEVEL, 0, "R6");
    op(0, 0, 1, I_TLEVEL, 3, "R6");
    op(1, 9, 0, 0, 0, "R8");
    op(0, 0, 1, I_PSTATE, 0, "R8");
    op(0, 0, 1, I_TLEVEL, 7, "R8");
    // R10 above max tl, unimplemented, R5 version write
    op(0, 0, 1, 10, 64'h77, "R10");
    op(1, 11, 0, 0, 0, "R10");
    op(0, 0, 1, 30, 64'h99, "R10");
    op(1, 31, 0, 0, 0, "R10");
    op(0, 0, 1, I_VERSION, 64'h1234, "R5");
    op(1, I_VERSION, 1, I_TLEVEL, 1, "R5");
    op(1, I_TLEVEL, 0, 0, 0, "R10");
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int wi = $urandom_range(0, 31);
      logic [63:0] wd = {$urandom, $urandom};
      if (wi == I_TLEVEL) wd = 64'($urandom_range(0, 7));
      op($urandom_range(0, 1) == 1, $urandom_range(0, 31), $urandom_range(0, 1) == 1, wi, wd, "RND R2 R4 R10");
    end
    @(negedge clk); rd_en = 0; wr_en = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule